// File: doc/BRIEF.md
# Flash Command Sequencer with Multi-Sector Erase

This block sits between a decoded host bus and the model of an eight-sector, 512 KB flash array. It watches byte writes on the bus and recognises the multi-cycle command language of the array: byte program, erase of one or several sectors, erase of the whole array, erase suspend and resume, identifier reads, reset and deep power down. When a command is complete it issues one operation request to the array model and holds a mask of the sectors being erased. It also tells the read path whether a read goes to the array, is answered with identifier data, or is not served at all.

Each sector carries a protection flag from outside the block. Protected sectors are never programmed or erased. Program and erase times are modelled by cycle counters set by parameters. A sector-erase command leaves a window open in which more sectors can be added. The window is measured in clock cycles and restarts with every sector that is accepted.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, readMode is 0 (array), busy is 0, eraseMask is 0, opStart is 0 and idValid is 0.
- R2: The unlock pair is AAh at 5555h, then 55h at 2AAAh. Addresses are compared on bits 14..0. After the pair, A0h at 5555h and then a write of any data at any address raises opStart for one cycle. This happens directly after the clock edge that captures the data write, with opKind 0 (program) and opAddr/opData equal to that write. busy then stays high for PROG_CYCLES cycles.
- R3: The sector of an address is given by bits 18..16. A program to a protected sector, or a first 30h that names a protected sector, produces no operation and returns readMode to 0. A further 30h naming a protected sector while the window is open is ignored and does not restart the window.
- R4: A write that does not match the next expected cycle of the unlock pair or of the erase prefix returns the block to readMode 0, and no operation is issued.
- R5: The unlock pair followed by 90h at 5555h sets readMode to 1. A read request is answered one cycle later with idValid, and idData is selected by address bits (A6,A1,A0): 000 gives MFR_CODE, 001 gives DEV_CODE, 010 gives the protection flag of the addressed sector in bit 0, and any other value gives 00h. Writes other than F0h, or AAh at 5555h, are ignored in this mode.
- R6: A single F0h at any address returns the block to readMode 0. So does the unlock pair followed by F0h. In readMode 0 a read request raises rdArray one cycle later, and idValid stays 0.
- R7: Sector erase is AAh, 55h, 80h, AAh, 55h, then 30h at an address in the sector. Each accepted 30h sets that sector's bit in eraseMask and restarts a window of WINDOW_CYCLES cycles. The erase request (opKind 1) is issued WINDOW_CYCLES cycles after the last accepted 30h, with eraseMask holding every collected sector.
- R8: The same five-cycle prefix followed by 10h at 5555h issues opKind 1 at once. eraseMask then equals the set of unprotected sectors. If every sector is protected, nothing is issued.
- R9: B0h at any address during an erase issues opKind 2, sets readMode to 3 and freezes the erase counter. A later 30h at any address issues opKind 3, and the erase finishes after the cycles it had left.
- R10: While an erase is suspended, a read of a sector outside eraseMask raises rdArray and a read inside it does not. Every write except 30h is ignored, including a complete program command.
- R11: 20h at 5555h in readMode 0 sets readMode to 4. In that mode reads raise neither rdArray nor idValid, writes other than F0h are ignored, and F0h returns the block to readMode 0.
- R12: An erase keeps busy high for ERASE_CYCLES running cycles, not counting suspended time. busy and eraseMask then clear together. While a program or erase runs, or while sectors are being collected, readMode is 2 and reads do not raise rdArray.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Bus write strobe, one cycle per byte |
| wrAddr | input | 19 | Bus write address |
| wrData | input | 8 | Bus write data |
| rdReq | input | 1 | Read request strobe |
| rdAddr | input | 19 | Read address |
| sectorProt | input | 8 | Per-sector protection flags, bit n for sector n |
| opStart | output | 1 | One-cycle operation request to the array model |
| opKind | output | 2 | 0 program, 1 erase, 2 suspend, 3 resume |
| opAddr | output | 19 | Address of a program request |
| opData | output | 8 | Data of a program request |
| eraseMask | output | 8 | Sectors taking part in the current erase |
| busy | output | 1 | Program or erase in progress (including suspended) |
| readMode | output | 3 | 0 array, 1 identifier, 2 busy, 3 suspended, 4 power down |
| rdArray | output | 1 | Read is passed to the array (one cycle after rdReq) |
| idValid | output | 1 | idData answers the previous read |
| idData | output | 8 | Identifier or protection byte |

## Verification
The bench uses three latencies. Mode changes and immediate requests (program, whole-array erase, suspend, resume) are visible right after the edge that captures the last write. Read answers appear one edge after the request. A collected sector erase starts exactly WINDOW_CYCLES edges after the last accepted 30h. The scoreboard attaches a due cycle to every expected request and compares it with the free-running edge count when opStart appears. Any request that was not predicted counts as a miscompare. The end of busy is checked on the cycle before and the cycle of its expected fall, with the suspended time added back.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    RM_ARRAY = 3'd0,
    RM_IDENT = 3'd1,
    RM_BUSY  = 3'd2,
    RM_SUSP  = 3'd3,
    RM_PDOWN = 3'd4
  } readMode_e;

  typedef enum logic [1:0] {
    OP_PROG    = 2'd0,
    OP_ERASE   = 2'd1,
    OP_SUSPEND = 2'd2,
    OP_RESUME  = 2'd3
  } opKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchOp;
    logic maskAdd;
    logic maskAll;
    logic maskClr;
  } dpCtl_t;

  localparam logic [14:0] KEY_HI = 15'h5555;
  localparam logic [14:0] KEY_LO = 15'h2AAA;

  localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
  localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
  localparam logic [7:0] CMD_ERASE    = 8'h80;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_SECTOR   = 8'h30;
  localparam logic [7:0] CMD_WHOLE    = 8'h10;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
  localparam logic [7:0] CMD_RESET    = 8'hF0;
  localparam logic [7:0] CMD_SLEEP    = 8'h20;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYCLES   = 8,
  parameter int ERASE_CYCLES  = 60,
  parameter int WINDOW_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [14:0] wrKey,
  input  logic [7:0]  wrData,
  input  logic        wrProt,
  input  logic        anyUnprot,
  output dpCtl_t      dpCtl,
  output logic        opStart,
  output logic [1:0]  opKind,
  output logic        busy,
  output logic [2:0]  readMode
);

  localparam int LONGEST = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam int WIN_W   = $clog2(WINDOW_CYCLES + 1);

  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_UNL2, S_PROGDATA, S_ERA1, S_ERA2, S_ERA3,
    S_WINDOW, S_PROGRAM, S_ERASE, S_SUSPEND, S_IDENT, S_PDOWN
  } state_e;

  state_e            st, stNxt;
  logic [CNT_W-1:0]  cnt, cntNxt;
  logic [WIN_W-1:0]  win, winNxt;
  logic              startNxt;
  opKind_e           kind, kindNxt;

  logic atHi, atLo, wrHi, unlockA, unlockB, isSector;
  assign atHi     = (wrKey == KEY_HI);
  assign atLo     = (wrKey == KEY_LO);
  assign wrHi     = wrEn && atHi;
  assign unlockA  = wrHi && (wrData == CMD_UNLOCK_A);
  assign unlockB  = wrEn && atLo && (wrData == CMD_UNLOCK_B);
  assign isSector = wrEn && (wrData == CMD_SECTOR);

  always_comb begin
    stNxt    = st;
    cntNxt   = cnt;
    winNxt   = win;
    startNxt = 1'b0;
    kindNxt  = kind;
    dpCtl    = '0;
    case (st)
      S_READ: begin
        if (unlockA) stNxt = S_UNL1;
        else if (wrHi && wrData == CMD_SLEEP) stNxt = S_PDOWN;
      end
      S_UNL1: if (wrEn) stNxt = unlockB ? S_UNL2 : S_READ;
      S_UNL2: if (wrEn) begin
        stNxt = S_READ;
        if (wrHi && wrData == CMD_IDENT)   stNxt = S_IDENT;
        if (wrHi && wrData == CMD_PROGRAM) stNxt = S_PROGDATA;
        if (wrHi && wrData == CMD_ERASE)   stNxt = S_ERA1;
      end
      S_PROGDATA: if (wrEn) begin
        if (wrProt) stNxt = S_READ;
        else begin
          dpCtl.latchOp = 1'b1;
          startNxt      = 1'b1;
          kindNxt       = OP_PROG;
          cntNxt        = CNT_W'(PROG_CYCLES);
          stNxt         = S_PROGRAM;
        end
      end
      S_ERA1: if (wrEn) stNxt = unlockA ? S_ERA2 : S_READ;
      S_ERA2: if (wrEn) stNxt = unlockB ? S_ERA3 : S_READ;
      S_ERA3: if (wrEn) begin
        stNxt = S_READ;
        if (wrHi && wrData == CMD_WHOLE && anyUnprot) begin
          dpCtl.maskAll = 1'b1;
          startNxt      = 1'b1;
          kindNxt       = OP_ERASE;
          cntNxt        = CNT_W'(ERASE_CYCLES);
          stNxt         = S_ERASE;
        end else if (isSector && !wrProt) begin
          dpCtl.maskAdd = 1'b1;
          winNxt        = WIN_W'(WINDOW_CYCLES);
          stNxt         = S_WINDOW;
        end
      end
      S_WINDOW: begin
        if (isSector && !wrProt) begin
          dpCtl.maskAdd = 1'b1;
          winNxt        = WIN_W'(WINDOW_CYCLES);
        end else if (win <= 1) begin
          startNxt = 1'b1;
          kindNxt  = OP_ERASE;
          cntNxt   = CNT_W'(ERASE_CYCLES);
          stNxt    = S_ERASE;
        end else begin
          winNxt = win - 1'b1;
        end
      end
      S_PROGRAM: begin
        if (cnt <= 1) stNxt = S_READ;
        else cntNxt = cnt - 1'b1;
      end
      S_ERASE: begin
        if (wrEn && wrData == CMD_SUSPEND) begin
          startNxt = 1'b1;
          kindNxt  = OP_SUSPEND;
          stNxt    = S_SUSPEND;
        end else if (cnt <= 1) begin
          dpCtl.maskClr = 1'b1;
          stNxt         = S_READ;
        end else begin
          cntNxt = cnt - 1'b1;
        end
      end
      S_SUSPEND: if (isSector) begin
        startNxt = 1'b1;
        kindNxt  = OP_RESUME;
        stNxt    = S_ERASE;
      end
      S_IDENT: if (wrEn) begin
        if (wrData == CMD_RESET) stNxt = S_READ;
        else if (unlockA)        stNxt = S_UNL1;
      end
      S_PDOWN: if (wrEn && wrData == CMD_RESET) stNxt = S_READ;
      default: stNxt = S_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= S_READ;
      cnt     <= '0;
      win     <= '0;
      opStart <= 1'b0;
      kind    <= OP_PROG;
    end else begin
      st      <= stNxt;
      cnt     <= cntNxt;
      win     <= winNxt;
      opStart <= startNxt;
      kind    <= kindNxt;
    end
  end

  assign opKind = kind;
  assign busy   = (st == S_PROGRAM) || (st == S_ERASE) || (st == S_SUSPEND);

  always_comb begin
    case (st)
      S_IDENT:                     readMode = RM_IDENT;
      S_WINDOW, S_PROGRAM, S_ERASE: readMode = RM_BUSY;
      S_SUSPEND:                   readMode = RM_SUSP;
      S_PDOWN:                     readMode = RM_PDOWN;
      default:                     readMode = RM_ARRAY;
    endcase
  end

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int          AW       = 19,
  parameter int          NS       = 8,
  parameter logic [7:0]  MFR_CODE = 8'h5A,
  parameter logic [7:0]  DEV_CODE = 8'hC3
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        dpCtl,
  input  logic [AW-1:0] wrAddr,
  input  logic [7:0]    wrData,
  input  logic          rdReq,
  input  logic [AW-1:0] rdAddr,
  input  logic [NS-1:0] sectorProt,
  input  logic [2:0]    readMode,
  output logic [AW-1:0] opAddr,
  output logic [7:0]    opData,
  output logic [NS-1:0] eraseMask,
  output logic          rdArray,
  output logic          idValid,
  output logic [7:0]    idData,
  output logic          wrProt,
  output logic          anyUnprot
);

  localparam int SW = $clog2(NS);

  logic [SW-1:0] wrSec, rdSec;
  assign wrSec     = wrAddr[AW-1 -: SW];
  assign rdSec     = rdAddr[AW-1 -: SW];
  assign wrProt    = sectorProt[wrSec];
  assign anyUnprot = |(~sectorProt);

  for (genvar g = 0; g < NS; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rstN)              eraseMask[g] <= 1'b0;
      else if (dpCtl.maskClr) eraseMask[g] <= 1'b0;
      else if (dpCtl.maskAll) eraseMask[g] <= ~sectorProt[g];
      else if (dpCtl.maskAdd && wrSec == SW'(g)) eraseMask[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAddr <= '0;
      opData <= '0;
    end else if (dpCtl.latchOp) begin
      opAddr <= wrAddr;
      opData <= wrData;
    end
  end

  logic [2:0] idSel;
  logic [7:0] idNxt;
  assign idSel = {rdAddr[6], rdAddr[1], rdAddr[0]};

  always_comb begin
    case (idSel)
      3'b000:  idNxt = MFR_CODE;
      3'b001:  idNxt = DEV_CODE;
      3'b010:  idNxt = {7'd0, sectorProt[rdSec]};
      default: idNxt = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdArray <= 1'b0;
      idValid <= 1'b0;
      idData  <= '0;
    end else begin
      rdArray <= rdReq && ((readMode == RM_ARRAY) ||
                           (readMode == RM_SUSP && !eraseMask[rdSec]));
      idValid <= rdReq && (readMode == RM_IDENT);
      idData  <= (rdReq && readMode == RM_IDENT) ? idNxt : 8'h00;
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W        = 19,
  parameter int         SECTORS       = 8,
  parameter int         PROG_CYCLES   = 8,
  parameter int         ERASE_CYCLES  = 60,
  parameter int         WINDOW_CYCLES = 16,
  parameter logic [7:0] MFR_CODE      = 8'h5A,
  parameter logic [7:0] DEV_CODE      = 8'hC3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [7:0]         wrData,
  input  logic               rdReq,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [SECTORS-1:0] sectorProt,
  output logic               opStart,
  output logic [1:0]         opKind,
  output logic [ADDR_W-1:0]  opAddr,
  output logic [7:0]         opData,
  output logic [SECTORS-1:0] eraseMask,
  output logic               busy,
  output logic [2:0]         readMode,
  output logic               rdArray,
  output logic               idValid,
  output logic [7:0]         idData
);

  dpCtl_t dpCtl;
  logic   wrProt, anyUnprot;

  flash_cmd_ctrl #(
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES),
    .WINDOW_CYCLES(WINDOW_CYCLES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrKey    (wrAddr[14:0]),
    .wrData   (wrData),
    .wrProt   (wrProt),
    .anyUnprot(anyUnprot),
    .dpCtl    (dpCtl),
    .opStart  (opStart),
    .opKind   (opKind),
    .busy     (busy),
    .readMode (readMode)
  );

  flash_cmd_dp #(
    .AW      (ADDR_W),
    .NS      (SECTORS),
    .MFR_CODE(MFR_CODE),
    .DEV_CODE(DEV_CODE)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtl     (dpCtl),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdReq     (rdReq),
    .rdAddr    (rdAddr),
    .sectorProt(sectorProt),
    .readMode  (readMode),
    .opAddr    (opAddr),
    .opData    (opData),
    .eraseMask (eraseMask),
    .rdArray   (rdArray),
    .idValid   (idValid),
    .idData    (idData),
    .wrProt    (wrProt),
    .anyUnprot (anyUnprot)
  );

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
#(
  parameter int AW = 19,
  parameter int NS = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic [NS-1:0] sectorProt,
  input logic          opStart,
  input logic [1:0]    opKind,
  input logic [AW-1:0] opAddr,
  input logic [NS-1:0] eraseMask,
  input logic          busy,
  input logic [2:0]    readMode,
  input logic          rdArray,
  input logic          idValid
);

  localparam int SW = $clog2(NS);

  // R3: a program request never targets a protected sector
  p_prog_unprotected_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opStart && opKind == OP_PROG) |-> !sectorProt[opAddr[AW-1 -: SW]]);

  // R8: an erase request never covers a protected sector
  p_mask_unprotected_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opStart && opKind == OP_ERASE) |-> ((eraseMask & sectorProt) == '0));

  // R7: an erase request always carries at least one sector
  p_mask_nonempty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (opStart && opKind == OP_ERASE) |-> (eraseMask != '0));

  // R12: program and erase requests are accompanied by busy
  p_busy_on_start_r12: assert property (@(posedge clk) disable iff (!rstN)
    (opStart && (opKind == OP_PROG || opKind == OP_ERASE)) |-> busy);

  // R9: a suspend request comes with the suspended read mode
  p_suspend_mode_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opStart && opKind == OP_SUSPEND) |-> (readMode == RM_SUSP));

  // R5: identifier answers only follow a read made in identifier mode
  p_ident_only_r5: assert property (@(posedge clk) disable iff (!rstN)
    idValid |-> ($past(readMode) == RM_IDENT));

  // R11: no array read is passed while powered down
  p_pdown_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (readMode == RM_PDOWN) |=> !rdArray);

endmodule

bind flash_cmd_seq flash_cmd_chk #(.AW(ADDR_W), .NS(SECTORS)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sectorProt(sectorProt),
  .opStart   (opStart),
  .opKind    (opKind),
  .opAddr    (opAddr),
  .eraseMask (eraseMask),
  .busy      (busy),
  .readMode  (readMode),
  .rdArray   (rdArray),
  .idValid   (idValid)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
  import flash_cmd_pkg::*;

  localparam int         PROG  = 8;
  localparam int         ERASE = 60;
  localparam int         WIN   = 16;
  localparam logic [7:0] MFR   = 8'h5A;
  localparam logic [7:0] DEV   = 8'hC3;

  logic        clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdReq = 1'b0;
  logic [18:0] wrAddr = '0, rdAddr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  sectorProt = 8'h84;   // sectors 2 and 7 protected
  logic        opStart, busy, rdArray, idValid;
  logic [1:0]  opKind;
  logic [18:0] opAddr;
  logic [7:0]  opData, eraseMask, idData;
  logic [2:0]  readMode;

  flash_cmd_seq #(
    .PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE), .WINDOW_CYCLES(WIN),
    .MFR_CODE(MFR), .DEV_CODE(DEV)
  ) i_flash_cmd_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdReq(rdReq), .rdAddr(rdAddr), .sectorProt(sectorProt),
    .opStart(opStart), .opKind(opKind), .opAddr(opAddr), .opData(opData),
    .eraseMask(eraseMask), .busy(busy), .readMode(readMode),
    .rdArray(rdArray), .idValid(idValid), .idData(idData)
  );

  always #4 clk = ~clk;   // 125 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChk = 0, nFail = 0, lastCyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    kind;
    int    mask;
    int    addr;
    int    data;
    int    due;
    string req;
  } exp_t;
  exp_t expQ[$];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input int mask, input int addr,
                      input int data, input int due, input string req);
    exp_t e;
    e.kind = kind; e.mask = mask; e.addr = addr; e.data = data;
    e.due = due; e.req = req;
    expQ.push_back(e);
  endtask

  // monitor: compare every request against the scoreboard
  always @(negedge clk) begin
    exp_t e;
    #1;
    if (rstN && opStart === 1'b1) begin
      if (expQ.size() == 0) begin
        nChk++; nFail++;
        $display("FAIL R3/R4/R10/R11 unexpected request: actual kind %0d expected none",
                 opKind);
      end else begin
        e = expQ.pop_front();
        check(e.req, "opKind", {30'd0, opKind}, e.kind);
        check(e.req, "due cycle", cyc, e.due);
        if (e.kind == OP_PROG) begin
          check(e.req, "opAddr", {13'd0, opAddr}, e.addr);
          check(e.req, "opData", {24'd0, opData}, e.data);
        end else begin
          check(e.req, "eraseMask", {24'd0, eraseMask}, e.mask);
        end
      end
    end
  end

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    lastCyc = cyc;
  endtask

  task automatic rd(input logic [18:0] a);
    @(negedge clk);
    rdReq = 1'b1; rdAddr = a;
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  task automatic unlock();
    wr(19'h05555, 8'hAA);
    wr(19'h02AAA, 8'h55);
  endtask

  task automatic erasePrefix();
    unlock();
    wr(19'h05555, 8'h80);
    unlock();
  endtask

  task automatic waitCyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    int s, b, m, r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "readMode", {29'd0, readMode}, 0);
    check("R1", "busy", {31'd0, busy}, 0);
    check("R1", "eraseMask", {24'd0, eraseMask}, 0);
    check("R1", "opStart", {31'd0, opStart}, 0);
    check("R1", "idValid", {31'd0, idValid}, 0);

    // R2 byte program
    unlock();
    wr(19'h05555, 8'hA0);
    wr(19'h12345, 8'h3C);
    push(OP_PROG, 0, 32'h12345, 32'h3C, lastCyc, "R2");
    s = lastCyc;
    check("R12", "readMode while programming", {29'd0, readMode}, RM_BUSY);
    waitCyc(s + PROG - 1);
    check("R2", "busy at last program cycle", {31'd0, busy}, 1);
    waitCyc(s + PROG);
    check("R2", "busy after program", {31'd0, busy}, 0);

    // R3 program aimed at protected sector 2
    unlock();
    wr(19'h05555, 8'hA0);
    wr(19'h20010, 8'h55);
    repeat (2) @(negedge clk);
    check("R3", "readMode after refused program", {29'd0, readMode}, RM_ARRAY);
    check("R3", "busy after refused program", {31'd0, busy}, 0);

    // R3 sector erase starting on protected sector 7
    erasePrefix();
    wr(19'h70000, 8'h30);
    repeat (WIN + 4) @(negedge clk);
    check("R3", "busy after refused erase", {31'd0, busy}, 0);
    check("R3", "eraseMask after refused erase", {24'd0, eraseMask}, 0);
    check("R3", "readMode after refused erase", {29'd0, readMode}, RM_ARRAY);

    // R4 broken unlock then program-like writes
    wr(19'h05555, 8'hAA);
    wr(19'h01234, 8'h55);
    wr(19'h05555, 8'hA0);
    wr(19'h10000, 8'h77);
    repeat (3) @(negedge clk);
    check("R4", "readMode after broken unlock", {29'd0, readMode}, RM_ARRAY);
    check("R4", "busy after broken unlock", {31'd0, busy}, 0);

    // R5 identifier mode
    unlock();
    wr(19'h05555, 8'h90);
    check("R5", "readMode", {29'd0, readMode}, RM_IDENT);
    rd(19'h00000);
    check("R5", "idValid", {31'd0, idValid}, 1);
    check("R5", "manufacturer code", {24'd0, idData}, MFR);
    check("R5", "rdArray in ident", {31'd0, rdArray}, 0);
    rd(19'h00001);
    check("R5", "device code", {24'd0, idData}, DEV);
    rd(19'h20002);
    check("R5", "protection of sector 2", {24'd0, idData}, 1);
    rd(19'h10002);
    check("R5", "protection of sector 1", {24'd0, idData}, 0);
    rd(19'h00040);
    check("R5", "unused selector", {24'd0, idData}, 0);
    wr(19'h01234, 8'hA0);
    check("R5", "stray write ignored", {29'd0, readMode}, RM_IDENT);

    // R6 single-cycle reset
    wr(19'h3ABCD, 8'hF0);
    check("R6", "readMode after F0", {29'd0, readMode}, RM_ARRAY);
    rd(19'h00100);
    check("R6", "rdArray in array mode", {31'd0, rdArray}, 1);
    check("R6", "idValid in array mode", {31'd0, idValid}, 0);
    // R6 unlock plus reset
    unlock();
    wr(19'h05555, 8'h90);
    unlock();
    wr(19'h00000, 8'hF0);
    check("R6", "readMode after unlock reset", {29'd0, readMode}, RM_ARRAY);

    // R7 multi-sector erase with window
    erasePrefix();
    wr(19'h30000, 8'h30);
    check("R12", "readMode while collecting", {29'd0, readMode}, RM_BUSY);
    repeat (5) @(negedge clk);
    wr(19'h50000, 8'h30);
    s = lastCyc + WIN;
    push(OP_ERASE, 32'h28, 0, 0, s, "R7");
    wr(19'h20000, 8'h30);   // protected, ignored, no restart (R3)
    rd(19'h60000);
    check("R12", "rdArray while collecting", {31'd0, rdArray}, 0);
    waitCyc(s - 1);
    check("R7", "collected mask", {24'd0, eraseMask}, 32'h28);
    check("R7", "busy before window end", {31'd0, busy}, 0);
    waitCyc(s);
    check("R7", "busy at erase start", {31'd0, busy}, 1);
    repeat (3) @(negedge clk);
    rd(19'h30000);
    check("R12", "rdArray while erasing", {31'd0, rdArray}, 0);

    // R9 suspend
    wr(19'h00000, 8'hB0);
    b = lastCyc;
    push(OP_SUSPEND, 32'h28, 0, 0, b, "R9");
    m = ERASE - (b - 1 - s);
    check("R9", "readMode suspended", {29'd0, readMode}, RM_SUSP);
    // R10 reads and writes while suspended
    rd(19'h40000);
    check("R10", "read outside mask", {31'd0, rdArray}, 1);
    rd(19'h50010);
    check("R10", "read inside mask", {31'd0, rdArray}, 0);
    unlock();
    wr(19'h05555, 8'hA0);
    wr(19'h40000, 8'h12);
    check("R10", "readMode after program attempt", {29'd0, readMode}, RM_SUSP);
    repeat (ERASE + 10) @(negedge clk);
    check("R9", "busy frozen while suspended", {31'd0, busy}, 1);
    check("R9", "mask kept while suspended", {24'd0, eraseMask}, 32'h28);
    wr(19'h00001, 8'h30);
    r = lastCyc;
    push(OP_RESUME, 32'h28, 0, 0, r, "R9");
    waitCyc(r + m - 1);
    check("R12", "busy before remaining cycles end", {31'd0, busy}, 1);
    waitCyc(r + m);
    check("R12", "busy after erase", {31'd0, busy}, 0);
    check("R12", "mask cleared after erase", {24'd0, eraseMask}, 0);

    // R8 whole-array erase
    erasePrefix();
    wr(19'h05555, 8'h10);
    s = lastCyc;
    push(OP_ERASE, 32'h7B, 0, 0, s, "R8");
    check("R8", "readMode whole erase", {29'd0, readMode}, RM_BUSY);
    waitCyc(s + ERASE - 1);
    check("R12", "busy last erase cycle", {31'd0, busy}, 1);
    waitCyc(s + ERASE);
    check("R12", "busy after whole erase", {31'd0, busy}, 0);

    // R11 deep power down
    wr(19'h05555, 8'h20);
    check("R11", "readMode power down", {29'd0, readMode}, RM_PDOWN);
    rd(19'h00100);
    check("R11", "rdArray in power down", {31'd0, rdArray}, 0);
    check("R11", "idValid in power down", {31'd0, idValid}, 0);
    unlock();
    wr(19'h05555, 8'hA0);
    wr(19'h10000, 8'h09);
    check("R11", "writes ignored in power down", {29'd0, readMode}, RM_PDOWN);
    wr(19'h00000, 8'hF0);
    check("R11", "readMode after wake", {29'd0, readMode}, RM_ARRAY);

    repeat (4) @(negedge clk);
    check("R2/R7/R8/R9", "scoreboard drained", expQ.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

endmodule